// File: doc/BRIEF.md
# Priority Command Queue with Collision-Aware Placement

This block holds pending memory commands for a DRAM controller and decides both where each new command lands in the queue and which queued command leaves next. Each slot stores a read/write flag, chip select, bank, row, source ID, a 4-bit priority and a small age counter. A new command is not simply appended. It moves ahead of entries with lower priority, but never ahead of an entry it conflicts with. A conflict is either a shared address where at least one of the two commands writes, or a shared source ID with the same command type. When priority allows, the new command also gathers next to queued commands of its own type.

Every cycle the front of the queue is scanned, up to the first sixteen slots. The earliest entry whose bank is marked ready in a per-bank vector is offered for popping. Queued entries age on a programmable cycle period. Each time an entry's age counter wraps, its priority improves by one step, stopping at the top level. The entry keeps its slot, so the raised priority only affects where later commands are placed.

Top module: `prio_cmd_queue`

## Requirements
- R1: After reset the queue is empty: `ins_ready` is 1 and `pop_valid` is 0 whatever `bank_ready` holds.
- R2: The priority input uses 15 as most urgent. It is stored inverted as 15 minus the input, so internally 0 is most urgent, and `pop_prio` shows the stored value.
- R3: A new command with no conflicts is placed just before the first entry whose stored priority is numerically greater than its own. Equal priorities keep arrival order.
- R4: A new command that shares chip select, bank and row with a queued entry, where either of the two is a write, is placed behind that entry even when its own priority is higher.
- R5: Two reads to the same chip select, bank and row do not conflict, so a more urgent read may pass an older read to that address.
- R6: Entries with the same source ID and the same type (both reads or both writes) keep arrival order. A read and a write from one source with different addresses may pass each other.
- R7: When the new command would land right after a run of entries that have its priority and the opposite type, and an entry of its own type sits just before that run, it is placed right after that entry. It never moves ahead of a conflicting entry.
- R8: A tick occurs every `age_period` cycles (every cycle for 0 or 1). On a tick each queued entry's 2-bit age advances. On the tick that wraps it from 3 to 0, the stored priority drops by one, saturating at 0. The entry does not move, and later placements use the new priority.
- R9: `pop_valid` is high when one of the first min(depth, 16) entries has its `bank_ready` bit (indexed by bank) set. The offered command is the earliest such entry, and it is removed when `pop_ready` is also high.
- R10: With all 8 slots taken, `ins_ready` is 0 and an offered command is dropped without changing the queue.
- R11: An insert and a pop in the same cycle both take effect. The pop choice and the placement are both computed on the queue as it stood before that edge, and the count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | New command offered |
| ins_ready | output | 1 | Queue can take a command |
| ins_write | input | 1 | 1 = write, 0 = read |
| ins_cs | input | 1 | Chip select of new command |
| ins_bank | input | 2 | Bank of new command |
| ins_row | input | 8 | Row of new command |
| ins_src | input | 4 | Source ID of new command |
| ins_prio | input | 4 | Urgency, 15 most urgent |
| age_period | input | 16 | Cycles between age ticks |
| bank_ready | input | 4 | Per-bank permission to issue |
| pop_valid | output | 1 | A command is offered |
| pop_ready | input | 1 | Consumer takes the offered command |
| pop_write | output | 1 | Type of offered command |
| pop_cs | output | 1 | Chip select of offered command |
| pop_bank | output | 2 | Bank of offered command |
| pop_row | output | 8 | Row of offered command |
| pop_src | output | 4 | Source ID of offered command |
| pop_prio | output | 4 | Stored priority, 0 most urgent |

## Verification
The hardest case is an insert and a pop landing on the same edge, because the removal shifts the slot the placement logic picked. The bench holds two equal-priority reads. It then offers a more urgent read while the front entry's bank is ready and `pop_ready` is high. It checks that the old front entry is the one offered in that cycle, that the new command ends up at the head, and that the remaining order and count are unchanged. An assertion also requires the entry count to stay constant across every such cycle.

// File: rtl/cq_pkg.sv
package cq_pkg;
    localparam int CS_W   = 1;
    localparam int BANK_W = 2;
    localparam int ROW_W  = 8;
    localparam int SRC_W  = 4;
    localparam int PRIO_W = 4;
    localparam int NBANK  = 1 << BANK_W;

    typedef struct packed {
        logic              wr;
        logic [CS_W-1:0]   cs;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [SRC_W-1:0]  src;
        logic [PRIO_W-1:0] prio;   // 0 = most urgent
    } cq_cmd_t;
endpackage

// File: rtl/cq_age_tick.sv
module cq_age_tick #(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] period,
    output logic                tick
);
    logic [PERIOD_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + 1'b1;
        tick  = 1'b0;
        if (period <= PERIOD_W'(1) || cnt_q >= period - 1'b1) begin
            tick  = 1'b1;
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/cq_place.sv
module cq_place
    import cq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input  cq_cmd_t [DEPTH-1:0] ents,
    input  logic [CNT_W-1:0]    count,
    input  cq_cmd_t             new_cmd,
    output logic [CNT_W-1:0]    pos
);
    logic [DEPTH-1:0] clash;    // entry must stay ahead of the new command
    logic [DEPTH-1:0] opp_eq;   // same priority, opposite type
    logic [DEPTH-1:0] same_ty;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        logic live, addr_hit, src_hit;
        assign live     = g < int'(count);
        assign addr_hit = ents[g].cs == new_cmd.cs && ents[g].bank == new_cmd.bank
                          && ents[g].row == new_cmd.row;
        assign src_hit  = ents[g].src == new_cmd.src && ents[g].wr == new_cmd.wr;
        assign clash[g]   = live && ((addr_hit && (ents[g].wr || new_cmd.wr)) || src_hit);
        assign opp_eq[g]  = live && ents[g].prio == new_cmd.prio && ents[g].wr != new_cmd.wr;
        assign same_ty[g] = live && ents[g].wr == new_cmd.wr;
    end

    always_comb begin
        int  lo, ppos, gpos;
        logic found, run;
        lo = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (clash[i]) lo = i + 1;
        end
        ppos  = int'(count);
        found = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!found && i < int'(count) && i >= lo && ents[i].prio > new_cmd.prio) begin
                ppos  = i;
                found = 1'b1;
            end
        end
        // grouping: hop back over equal-priority opposite-type entries
        gpos = ppos;
        run  = 1'b1;
        for (int i = DEPTH - 1; i >= 1; i--) begin
            if (i < ppos && run) begin
                if (opp_eq[i] && i >= lo) begin
                    if (same_ty[i-1]) gpos = i;
                end else begin
                    run = 1'b0;
                end
            end
        end
        pos = CNT_W'(gpos);
    end
endmodule

// File: rtl/cq_select.sv
module cq_select
    import cq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int SCAN_N = 8,
    parameter int CNT_W  = 4,
    parameter int IDX_W  = 3
) (
    input  cq_cmd_t [DEPTH-1:0] ents,
    input  logic [CNT_W-1:0]    count,
    input  logic [NBANK-1:0]    bank_ready,
    output logic                hit,
    output logic [IDX_W-1:0]    sel
);
    always_comb begin
        hit = 1'b0;
        sel = '0;
        for (int i = 0; i < SCAN_N; i++) begin
            if (!hit && i < int'(count) && bank_ready[ents[i].bank]) begin
                hit = 1'b1;
                sel = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/prio_cmd_queue.sv
module prio_cmd_queue
    import cq_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int SCAN_MAX = 16,
    parameter int AGE_W    = 2,
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ins_valid,
    output logic                ins_ready,
    input  logic                ins_write,
    input  logic [CS_W-1:0]     ins_cs,
    input  logic [BANK_W-1:0]   ins_bank,
    input  logic [ROW_W-1:0]    ins_row,
    input  logic [SRC_W-1:0]    ins_src,
    input  logic [PRIO_W-1:0]   ins_prio,
    input  logic [PERIOD_W-1:0] age_period,
    input  logic [NBANK-1:0]    bank_ready,
    output logic                pop_valid,
    input  logic                pop_ready,
    output logic                pop_write,
    output logic [CS_W-1:0]     pop_cs,
    output logic [BANK_W-1:0]   pop_bank,
    output logic [ROW_W-1:0]    pop_row,
    output logic [SRC_W-1:0]    pop_src,
    output logic [PRIO_W-1:0]   pop_prio
);
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int SCAN_N = (DEPTH < SCAN_MAX) ? DEPTH : SCAN_MAX;
    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    typedef struct packed {
        cq_cmd_t [DEPTH-1:0]         ent;
        logic [DEPTH-1:0][AGE_W-1:0] age;
        logic [CNT_W-1:0]            cnt;
    } state_t;

    state_t st_d, st_q;

    cq_cmd_t                     new_cmd;
    logic [CNT_W-1:0]            place_pos;
    logic [IDX_W-1:0]            sel;
    logic                        hit, tick, ins_fire, pop_fire;
    cq_cmd_t [DEPTH-1:0]         aged_e, pe;
    logic [DEPTH-1:0][AGE_W-1:0] aged_a, pa;

    assign new_cmd = '{wr: ins_write, cs: ins_cs, bank: ins_bank, row: ins_row,
                       src: ins_src, prio: ~ins_prio};

    cq_age_tick #(.PERIOD_W(PERIOD_W)) tick_i (
        .clk(clk), .rst_n(rst_n), .period(age_period), .tick(tick)
    );

    cq_place #(.DEPTH(DEPTH), .CNT_W(CNT_W)) place_i (
        .ents(st_q.ent), .count(st_q.cnt), .new_cmd(new_cmd), .pos(place_pos)
    );

    cq_select #(.DEPTH(DEPTH), .SCAN_N(SCAN_N), .CNT_W(CNT_W), .IDX_W(IDX_W)) select_i (
        .ents(st_q.ent), .count(st_q.cnt), .bank_ready(bank_ready), .hit(hit), .sel(sel)
    );

    assign ins_ready = st_q.cnt != CNT_W'(DEPTH);
    assign ins_fire  = ins_valid && ins_ready;
    assign pop_valid = hit;
    assign pop_fire  = hit && pop_ready;
    assign pop_write = st_q.ent[sel].wr;
    assign pop_cs    = st_q.ent[sel].cs;
    assign pop_bank  = st_q.ent[sel].bank;
    assign pop_row   = st_q.ent[sel].row;
    assign pop_src   = st_q.ent[sel].src;
    assign pop_prio  = st_q.ent[sel].prio;

    always_comb begin
        int ip;
        st_d   = st_q;
        aged_e = st_q.ent;
        aged_a = st_q.age;
        // aging: priority climbs in place
        for (int i = 0; i < DEPTH; i++) begin
            if (tick && i < int'(st_q.cnt)) begin
                if (aged_a[i] == AGE_MAX) begin
                    aged_a[i] = '0;
                    if (aged_e[i].prio != '0) aged_e[i].prio = aged_e[i].prio - 1'b1;
                end else begin
                    aged_a[i] = aged_a[i] + 1'b1;
                end
            end
        end
        // removal of the popped slot
        pe = aged_e;
        pa = aged_a;
        if (pop_fire) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                if (i >= int'(sel)) begin
                    pe[i] = aged_e[i+1];
                    pa[i] = aged_a[i+1];
                end
            end
            pe[DEPTH-1] = '0;
            pa[DEPTH-1] = '0;
        end
        // insertion at the computed slot, corrected for the removal
        ip = int'(place_pos) - ((pop_fire && int'(sel) < int'(place_pos)) ? 1 : 0);
        st_d.ent = pe;
        st_d.age = pa;
        if (ins_fire) begin
            if (ip == 0) begin
                st_d.ent[0] = new_cmd;
                st_d.age[0] = '0;
            end
            for (int i = 1; i < DEPTH; i++) begin
                if (i == ip) begin
                    st_d.ent[i] = new_cmd;
                    st_d.age[i] = '0;
                end else if (i > ip) begin
                    st_d.ent[i] = pe[i-1];
                    st_d.age[i] = pa[i-1];
                end
            end
        end
        st_d.cnt = st_q.cnt + CNT_W'(ins_fire) - CNT_W'(pop_fire);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_empty_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt == '0 |-> !pop_valid);

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));

    p_full_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !ins_ready && !pop_fire) |=> $stable(st_q.cnt));

    p_swap_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_fire && pop_fire) |=> $stable(st_q.cnt));

    p_pop_bank_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pop_valid |-> bank_ready[pop_bank]);

    p_prio_climb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ins_fire && !pop_fire && st_q.cnt != '0)
        |=> st_q.ent[0].prio <= $past(st_q.ent[0].prio));

    p_no_move_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ins_fire && !pop_fire && st_q.cnt != '0)
        |=> $stable(st_q.ent[0].row) && $stable(st_q.ent[0].src));
endmodule

// File: tb/prio_cmd_queue_tb_top.sv
module prio_cmd_queue_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic       pop;    // 0 = insert, 1 = pop and compare
        logic       wr;
        logic [1:0] bank;
        logic [7:0] row;
        logic [3:0] src;
        logic [3:0] prio;   // insert: input urgency; pop: expected stored value
        logic [3:0] req;
    } step_t;

    localparam int NSTEP = 30;
    localparam step_t TBL [NSTEP] = '{
        // R2 / R3: ordering by priority, arrival order within a level
        '{1'b0, 1'b0, 2'd0, 8'd1,  4'd1, 4'd2,  4'd3},
        '{1'b0, 1'b0, 2'd0, 8'd2,  4'd2, 4'd5,  4'd3},
        '{1'b0, 1'b0, 2'd0, 8'd3,  4'd3, 4'd2,  4'd3},
        '{1'b0, 1'b0, 2'd0, 8'd4,  4'd4, 4'd15, 4'd3},
        '{1'b1, 1'b0, 2'd0, 8'd4,  4'd4, 4'd0,  4'd2},
        '{1'b1, 1'b0, 2'd0, 8'd2,  4'd2, 4'd10, 4'd3},
        '{1'b1, 1'b0, 2'd0, 8'd1,  4'd1, 4'd13, 4'd3},
        '{1'b1, 1'b0, 2'd0, 8'd3,  4'd3, 4'd13, 4'd3},
        // R4: read behind a write to the same row
        '{1'b0, 1'b1, 2'd1, 8'd5,  4'd1, 4'd1,  4'd4},
        '{1'b0, 1'b0, 2'd1, 8'd5,  4'd2, 4'd14, 4'd4},
        '{1'b0, 1'b0, 2'd2, 8'd6,  4'd3, 4'd14, 4'd4},
        '{1'b1, 1'b0, 2'd2, 8'd6,  4'd3, 4'd1,  4'd4},
        '{1'b1, 1'b1, 2'd1, 8'd5,  4'd1, 4'd14, 4'd4},
        '{1'b1, 1'b0, 2'd1, 8'd5,  4'd2, 4'd1,  4'd4},
        // R5: read passes read to the same row
        '{1'b0, 1'b0, 2'd1, 8'd7,  4'd1, 4'd0,  4'd5},
        '{1'b0, 1'b0, 2'd1, 8'd7,  4'd2, 4'd9,  4'd5},
        '{1'b1, 1'b0, 2'd1, 8'd7,  4'd2, 4'd6,  4'd5},
        '{1'b1, 1'b0, 2'd1, 8'd7,  4'd1, 4'd15, 4'd5},
        // R6: same-source reads in order, same-source write passes
        '{1'b0, 1'b0, 2'd0, 8'd8,  4'd5, 4'd0,  4'd6},
        '{1'b0, 1'b0, 2'd0, 8'd9,  4'd5, 4'd15, 4'd6},
        '{1'b0, 1'b1, 2'd0, 8'd10, 4'd5, 4'd15, 4'd6},
        '{1'b1, 1'b1, 2'd0, 8'd10, 4'd5, 4'd0,  4'd6},
        '{1'b1, 1'b0, 2'd0, 8'd8,  4'd5, 4'd15, 4'd6},
        '{1'b1, 1'b0, 2'd0, 8'd9,  4'd5, 4'd0,  4'd6},
        // R7: new read joins the queued read ahead of a write
        '{1'b0, 1'b0, 2'd0, 8'd11, 4'd1, 4'd3,  4'd7},
        '{1'b0, 1'b1, 2'd0, 8'd12, 4'd2, 4'd3,  4'd7},
        '{1'b0, 1'b0, 2'd0, 8'd13, 4'd3, 4'd3,  4'd7},
        '{1'b1, 1'b0, 2'd0, 8'd11, 4'd1, 4'd12, 4'd7},
        '{1'b1, 1'b0, 2'd0, 8'd13, 4'd3, 4'd12, 4'd7},
        '{1'b1, 1'b1, 2'd0, 8'd12, 4'd2, 4'd12, 4'd7}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ins_valid = 1'b0, ins_write = 1'b0, pop_ready = 1'b0;
    logic [0:0]  ins_cs = '0;
    logic [1:0]  ins_bank = '0;
    logic [7:0]  ins_row = '0;
    logic [3:0]  ins_src = '0, ins_prio = '0;
    logic [15:0] age_period = 16'hFFFF;
    logic [3:0]  bank_ready = '0;
    logic        ins_ready, pop_valid, pop_write;
    logic [0:0]  pop_cs;
    logic [1:0]  pop_bank;
    logic [7:0]  pop_row;
    logic [3:0]  pop_src, pop_prio;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    prio_cmd_queue dut_i (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
        .ins_write(ins_write), .ins_cs(ins_cs), .ins_bank(ins_bank), .ins_row(ins_row),
        .ins_src(ins_src), .ins_prio(ins_prio), .age_period(age_period),
        .bank_ready(bank_ready), .pop_valid(pop_valid), .pop_ready(pop_ready),
        .pop_write(pop_write), .pop_cs(pop_cs), .pop_bank(pop_bank), .pop_row(pop_row),
        .pop_src(pop_src), .pop_prio(pop_prio)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic put(input logic wr, input logic [1:0] bank, input logic [7:0] row,
                       input logic [3:0] src, input logic [3:0] prio);
        @(negedge clk);
        ins_valid = 1'b1; ins_write = wr; ins_bank = bank; ins_row = row;
        ins_src = src; ins_prio = prio;
        @(posedge clk);
        #1 ins_valid = 1'b0;
    endtask

    // offer with the given bank mask, compare {valid, wr, row, src, prio}, then pop
    task automatic take(input logic [3:0] mask, input logic wr, input logic [7:0] row,
                        input logic [3:0] src, input logic [3:0] prio, input string tag);
        @(negedge clk);
        bank_ready = mask; pop_ready = 1'b1;
        #1 check(tag, {pop_valid, pop_write, pop_row, pop_src, pop_prio},
                      {1'b1, wr, row, src, prio});
        @(posedge clk);
        #1 begin pop_ready = 1'b0; bank_ready = '0; end
    endtask

    task automatic expect_empty(input string tag);
        @(negedge clk);
        bank_ready = '1;
        #1 check(tag, {31'd0, pop_valid}, 32'd0);
        bank_ready = '0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: empty after reset
        @(negedge clk);
        bank_ready = '1;
        #1 check("R1 reset ready/valid", {30'd0, ins_ready, pop_valid}, {30'd0, 2'b10});
        bank_ready = '0;

        for (int k = 0; k < NSTEP; k++) begin
            if (!TBL[k].pop)
                put(TBL[k].wr, TBL[k].bank, TBL[k].row, TBL[k].src, TBL[k].prio);
            else
                take(4'hF, TBL[k].wr, TBL[k].row, TBL[k].src, TBL[k].prio,
                     $sformatf("R%0d table step %0d", TBL[k].req, k));
        end
        expect_empty("R3 table drained");

        // R9: bank-ready driven selection
        put(1'b0, 2'd0, 8'd20, 4'd1, 4'd0);
        put(1'b0, 2'd1, 8'd21, 4'd2, 4'd0);
        put(1'b0, 2'd2, 8'd22, 4'd3, 4'd0);
        @(negedge clk);
        bank_ready = 4'b0000;
        #1 check("R9 no ready bank", {31'd0, pop_valid}, 32'd0);
        bank_ready = 4'b0110;
        #1 check("R9 earliest ready", {23'd0, pop_valid, pop_row}, {23'd0, 1'b1, 8'd21});
        bank_ready = '0;
        take(4'b0100, 1'b0, 8'd22, 4'd3, 4'd15, "R9 pop bank2 first");
        take(4'hF, 1'b0, 8'd20, 4'd1, 4'd15, "R9 then front");
        take(4'hF, 1'b0, 8'd21, 4'd2, 4'd15, "R9 then next");

        // R10: full queue drops an offer
        for (int i = 0; i < 8; i++) put(1'b0, 2'd0, 8'(50 + i), 4'(i), 4'd0);
        @(negedge clk);
        #1 check("R10 full ready low", {31'd0, ins_ready}, 32'd0);
        put(1'b0, 2'd0, 8'd99, 4'd9, 4'd15);
        for (int i = 0; i < 8; i++)
            take(4'hF, 1'b0, 8'(50 + i), 4'(i), 4'd15, "R10 contents kept");
        expect_empty("R10 dropped command absent");

        // R11: insert and pop on the same edge
        put(1'b0, 2'd0, 8'd30, 4'd1, 4'd0);
        put(1'b0, 2'd0, 8'd31, 4'd2, 4'd0);
        @(negedge clk);
        ins_valid = 1'b1; ins_write = 1'b0; ins_bank = 2'd0; ins_row = 8'd32;
        ins_src = 4'd3; ins_prio = 4'd15; bank_ready = '1; pop_ready = 1'b1;
        #1 check("R11 old front offered", {24'd0, pop_row}, {24'd0, 8'd30});
        @(posedge clk);
        #1 begin ins_valid = 1'b0; pop_ready = 1'b0; bank_ready = '0; end
        take(4'hF, 1'b0, 8'd32, 4'd3, 4'd0, "R11 new at head");
        take(4'hF, 1'b0, 8'd31, 4'd2, 4'd15, "R11 survivor");
        expect_empty("R11 count kept");

        // R8: aging with a tick every 2 cycles
        @(negedge clk);
        age_period = 16'd2;
        repeat (2) @(posedge clk);
        put(1'b0, 2'd0, 8'd40, 4'd1, 4'd0);
        repeat (19) @(posedge clk);
        @(negedge clk);
        bank_ready = '1;
        #1 check("R8 two levels after ten ticks", {28'd0, pop_prio}, 32'd13);
        bank_ready = '0;
        repeat (200) @(posedge clk);
        put(1'b0, 2'd1, 8'd41, 4'd2, 4'd15);
        take(4'hF, 1'b0, 8'd40, 4'd1, 4'd0, "R8 saturated, placed ahead of later equal");
        take(4'hF, 1'b0, 8'd41, 4'd2, 4'd0, "R8 later entry behind");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule